// File: doc/BRIEF.md
# Split-Word Seconds Counter with Alarm

This block keeps a 48-bit seconds count for a real-time clock. A slow tick enable at 32.768 kHz drives a prescaler, and the count advances by one each time the prescaler wraps. Software reaches the count through a plain 32-bit register port. The low 32 bits sit in one word and the upper 16 bits sit in a second word. An optional freeze mode makes a low-then-high read pair coherent. When software reads the low word, the high half is captured, and the next read of the high word returns that captured value even if a carry has happened in between.

A 48-bit alarm compare register, split into words in the same way, raises an event when the count becomes equal to it. A second event input from outside the block shares the same interrupt logic. Each source has a raw status bit that is cleared by writing one. Enables are set and cleared through separate write-one registers. A masked status view combines the two, and a level interrupt output is the OR of the masked bits.

Register offsets, in bytes on an 8-bit address:
- 0x08: count, low 32 bits.
- 0x0C: count, upper 16 bits in bits 15:0.
- 0x20 and 0x24: alarm, same split as the count.
- 0x50: control word, freeze-mode field in bits 25:24.
- 0x54: raw status.
- 0x58: masked status and write-one-to-clear.
- 0x5C: enable set.
- 0x60: enable clear.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset, all of the following hold:
  - the count reads 0 in both words;
  - the alarm reads all ones (low word 0xFFFFFFFF, high word 0x0000FFFF);
  - the control word, raw status (0x54), masked status and enables read 0;
  - `irq_o` is low.
- R2: The count rises by exactly one for every TICK_DIV cycles on which `tick_i` is high. Cycles with `tick_i` low do not advance the prescaler.
- R3: Writing to the time registers works as follows:
  - a write to 0x08 replaces count bits 31:0;
  - a write to 0x0C replaces count bits 47:32 with write data bits 15:0, and data bits 31:16 are ignored;
  - when a count write and a prescaler wrap fall in the same cycle, the write wins and that increment is dropped.
- R4: With the freeze field at 0x50 bits 25:24 equal to 2, reading 0x08 captures count bits 47:32. The next read of 0x0C returns the captured value, even if the count has since carried, and that read releases the capture. Any later 0x0C read returns the live value.
- R5: With the freeze field at any other value, a read of 0x0C returns the live upper count.
- R6: Read data appears on `bus_rdata_o` after the clock edge that samples `bus_rd_i`. It holds its value on cycles without a read.
- R7: Raw status bit 0 is set in the cycle after the count becomes equal to the alarm in all 48 bits. An alarm that differs from the count in a single bit sets nothing.
- R8: Writing 1 to bit n of 0x5C sets enable n, and writing 1 to bit n of 0x60 clears it. Zero bits have no effect. Both offsets read back the enables in bits 1:0, and 0x58 reads raw status AND enables.
- R9: Writing 1 to bit n of 0x58 clears raw bit n, and zero bits leave it alone. If a source event arrives in the same cycle as a clear, the event wins.
- R10: A one-cycle pulse on `evt_ext_i` sets raw status bit 1.
- R11: `irq_o` is high exactly while some raw status bit and its enable are both set. It stays high until the bit is cleared or disabled.
- R12: The count wraps from 0xFFFF_FFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle wide |
| evt_ext_i | input | 1 | Second event source, sets raw bit 1 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt, OR of masked status |

## Verification
On every cycle, the assertions check the following:
- the count moves only after a prescaler wrap or a count write;
- a low-word write lands on the next cycle;
- status bits and enables change only through their own write-one offsets;
- read data holds between reads;
- a high-word read taken while frozen returns the captured half;
- the interrupt rises and falls only for a legitimate cause.

Only the bench scenarios show the rest. These are the arithmetic of the prescaler and count over swept tick counts, carry across the word boundary during a frozen read pair, wrap at full scale, exact 48-bit alarm matching against single-bit near misses, and the event-wins ordering of a simultaneous set and clear.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int unsigned CNT_W = 48;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned N_SRC = 2;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_ALM_LO = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_ALM_HI = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_EN_SET = 8'h5C;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR = 8'h60;

  localparam int unsigned FRZ_LSB = 24;

  typedef enum logic [1:0] {
    FRZ_OFF   = 2'd0,
    FRZ_RSV1  = 2'd1,
    FRZ_LATCH = 2'd2,
    FRZ_RSV3  = 2'd3
  } frz_mode_e;
endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wrap_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap_o ? '0 : cnt_q + PW'(1);
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned W  = 48,
  parameter int unsigned LW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [LW-1:0]   lo_i,
  input  logic [W-LW-1:0] hi_i,
  output logic [W-1:0]    cnt_o
);
  logic [W-1:0] cnt_q;

  // a software write takes priority over the increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_q[LW-1:0] <= lo_i;
      if (wr_hi_i) cnt_q[W-1:LW] <= hi_i;
    end else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned W  = 48,
  parameter int unsigned LW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    cnt_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [LW-1:0]   lo_i,
  input  logic [W-LW-1:0] hi_i,
  output logic [W-1:0]    alm_o,
  output logic            evt_o
);
  logic [W-1:0] alm_q;
  logic         match;
  logic         match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alm_q <= '1;
    else begin
      if (wr_lo_i) alm_q[LW-1:0] <= lo_i;
      if (wr_hi_i) alm_q[W-1:LW] <= hi_i;
    end
  end

  assign match = (cnt_i == alm_q);

  // event on entry into equality only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else match_q <= match;
  end

  assign evt_o = match && !match_q;
  assign alm_o = alm_q;
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_set_i,
  input  logic [N-1:0] en_clr_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q;
  logic [N-1:0] en_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        raw_q[i] <= 1'b0;
        en_q[i]  <= 1'b0;
      end else begin
        // set beats clear
        if (set_i[i]) raw_q[i] <= 1'b1;
        else if (clr_i[i]) raw_q[i] <= 1'b0;
        if (en_set_i[i]) en_q[i] <= 1'b1;
        else if (en_clr_i[i]) en_q[i] <= 1'b0;
      end
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = |(raw_q & en_q);
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
  import rtc_sec_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              evt_ext_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned LW = BUS_W;
  localparam int unsigned HW = CNT_W - LW;

  logic             sec_pulse;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] alm_q;
  logic             alm_evt;
  logic [N_SRC-1:0] raw_q;
  logic [N_SRC-1:0] en_q;
  frz_mode_e        mode_q;
  logic             frz_q;
  logic [HW-1:0]    snap_q;
  logic [BUS_W-1:0] rd_val;

  logic wr_cnt_lo, wr_cnt_hi, wr_alm_lo, wr_alm_hi, wr_ctrl, wr_stat, wr_en_set, wr_en_clr;
  logic rd_cnt_lo, rd_cnt_hi;

  assign wr_cnt_lo = bus_wr_i && (bus_addr_i == OFF_CNT_LO);
  assign wr_cnt_hi = bus_wr_i && (bus_addr_i == OFF_CNT_HI);
  assign wr_alm_lo = bus_wr_i && (bus_addr_i == OFF_ALM_LO);
  assign wr_alm_hi = bus_wr_i && (bus_addr_i == OFF_ALM_HI);
  assign wr_ctrl   = bus_wr_i && (bus_addr_i == OFF_CTRL);
  assign wr_stat   = bus_wr_i && (bus_addr_i == OFF_STAT);
  assign wr_en_set = bus_wr_i && (bus_addr_i == OFF_EN_SET);
  assign wr_en_clr = bus_wr_i && (bus_addr_i == OFF_EN_CLR);
  assign rd_cnt_lo = bus_rd_i && (bus_addr_i == OFF_CNT_LO);
  assign rd_cnt_hi = bus_rd_i && (bus_addr_i == OFF_CNT_HI);

  rtc_tick_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .wrap_o (sec_pulse)
  );

  rtc_sec_counter #(.W(CNT_W), .LW(LW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (sec_pulse),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .lo_i    (bus_wdata_i),
    .hi_i    (bus_wdata_i[HW-1:0]),
    .cnt_o   (cnt_q)
  );

  rtc_alarm_cmp #(.W(CNT_W), .LW(LW)) u_alm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_q),
    .wr_lo_i (wr_alm_lo),
    .wr_hi_i (wr_alm_hi),
    .lo_i    (bus_wdata_i),
    .hi_i    (bus_wdata_i[HW-1:0]),
    .alm_o   (alm_q),
    .evt_o   (alm_evt)
  );

  rtc_irq_regs #(.N(N_SRC)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    ({evt_ext_i, alm_evt}),
    .clr_i    (wr_stat ? bus_wdata_i[N_SRC-1:0] : '0),
    .en_set_i (wr_en_set ? bus_wdata_i[N_SRC-1:0] : '0),
    .en_clr_i (wr_en_clr ? bus_wdata_i[N_SRC-1:0] : '0),
    .raw_o    (raw_q),
    .en_o     (en_q),
    .irq_o    (irq_o)
  );

  // freeze control and high-half capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= FRZ_OFF;
      frz_q  <= 1'b0;
      snap_q <= '0;
    end else if (wr_ctrl) begin
      mode_q <= frz_mode_e'(bus_wdata_i[FRZ_LSB+1:FRZ_LSB]);
      frz_q  <= 1'b0;
    end else if (rd_cnt_lo && (mode_q == FRZ_LATCH)) begin
      frz_q  <= 1'b1;
      snap_q <= cnt_q[CNT_W-1:LW];
    end else if (rd_cnt_hi) begin
      frz_q  <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (bus_addr_i)
      OFF_CNT_LO: rd_val = cnt_q[LW-1:0];
      OFF_CNT_HI: rd_val[HW-1:0] = frz_q ? snap_q : cnt_q[CNT_W-1:LW];
      OFF_ALM_LO: rd_val = alm_q[LW-1:0];
      OFF_ALM_HI: rd_val[HW-1:0] = alm_q[CNT_W-1:LW];
      OFF_CTRL:   rd_val[FRZ_LSB+1:FRZ_LSB] = mode_q;
      OFF_RAW:    rd_val[N_SRC-1:0] = raw_q;
      OFF_STAT:   rd_val[N_SRC-1:0] = raw_q & en_q;
      OFF_EN_SET: rd_val[N_SRC-1:0] = en_q;
      OFF_EN_CLR: rd_val[N_SRC-1:0] = en_q;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_val;
  end
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk
  import rtc_sec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_ext_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [BUS_W-1:0]  bus_wdata_i,
  input logic [BUS_W-1:0]  bus_rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              sec_pulse,
  input logic              alm_evt,
  input logic [N_SRC-1:0]  raw_q,
  input logic [N_SRC-1:0]  en_q,
  input logic              frz_q,
  input logic [15:0]       snap_q
);
  // R2
  cnt_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> $past(sec_pulse || (bus_wr_i &&
      (bus_addr_i == OFF_CNT_LO || bus_addr_i == OFF_CNT_HI))));

  // R3
  cnt_wr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_wr_i) && $past(bus_addr_i) == OFF_CNT_LO) |-> cnt_q[31:0] == $past(bus_wdata_i));

  // R4
  frz_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_rd_i) && $past(bus_addr_i) == OFF_CNT_HI && $past(frz_q))
      |-> bus_rdata_o == {16'h0, $past(snap_q)});

  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_rd_i) |-> $stable(bus_rdata_o));

  // R8
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q[0]) |-> $past(bus_wr_i && bus_addr_i == OFF_EN_SET && bus_wdata_i[0]));

  // R8
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q[0]) |-> $past(bus_wr_i && bus_addr_i == OFF_EN_CLR && bus_wdata_i[0]));

  // R9
  raw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(raw_q[0]) |-> $past(bus_wr_i && bus_addr_i == OFF_STAT && bus_wdata_i[0]));

  // R11
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(alm_evt || evt_ext_i || (bus_wr_i && bus_addr_i == OFF_EN_SET)));

  // R11
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(bus_wr_i && (bus_addr_i == OFF_STAT || bus_addr_i == OFF_EN_CLR)));
endmodule

bind rtc_seconds_core rtc_seconds_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_ext_i   (evt_ext_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .cnt_q       (cnt_q),
  .sec_pulse   (sec_pulse),
  .alm_evt     (alm_evt),
  .raw_q       (raw_q),
  .en_q        (en_q),
  .frz_q       (frz_q),
  .snap_q      (snap_q)
);

// File: tb/tb_rtc_seconds_core.sv
`timescale 1ns/1ps
module tb_rtc_seconds_core;
  import rtc_sec_pkg::*;

  localparam int PRE = 4;
  localparam time CYC = 20ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        evt_ext_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [47:0] m_sec = '0;
  int          m_ph = 0;

  always #(CYC/2) clk_i = ~clk_i;

  rtc_seconds_core #(.TICK_DIV(PRE)) dut (
    .clk_i, .rst_ni, .tick_i, .evt_ext_i, .bus_wr_i, .bus_rd_i,
    .bus_addr_i, .bus_wdata_i, .bus_rdata_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk_i);
    bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
    v = bus_rdata_o;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      m_ph++;
      if (m_ph == PRE) begin m_ph = 0; m_sec = m_sec + 48'd1; end
    end
    @(negedge clk_i);
    tick_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic set_time(input logic [47:0] t);
    wr(OFF_CNT_LO, t[31:0]);
    wr(OFF_CNT_HI, {16'h0, t[47:32]});
    m_sec = t;
  endtask

  task automatic set_alarm(input logic [47:0] t);
    wr(OFF_ALM_LO, t[31:0]);
    wr(OFF_ALM_HI, {16'h0, t[47:32]});
  endtask

  task automatic chk_time(input string req);
    rd_chk(req, OFF_CNT_LO, m_sec[31:0]);
    rd_chk(req, OFF_CNT_HI, {16'h0, m_sec[47:32]});
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    rd_chk("R1 cnt_lo", OFF_CNT_LO, 32'h0);
    rd_chk("R1 cnt_hi", OFF_CNT_HI, 32'h0);
    rd_chk("R1 alm_lo", OFF_ALM_LO, 32'hFFFF_FFFF);
    rd_chk("R1 alm_hi", OFF_ALM_HI, 32'h0000_FFFF);
    rd_chk("R1 ctrl", OFF_CTRL, 32'h0);
    rd_chk("R1 raw", OFF_RAW, 32'h0);
    rd_chk("R1 stat", OFF_STAT, 32'h0);
    rd_chk("R1 en", OFF_EN_SET, 32'h0);

    // R2 sweep of tick counts, with idle gaps
    for (int n = 0; n < 10; n++) begin
      tick_n(n);
      repeat (n) @(negedge clk_i);
      chk_time("R2 sweep");
    end

    // R12 full-scale wrap
    set_time(48'hFFFF_FFFF_FFFF);
    tick_n(PRE - m_ph);
    chk_time("R12 wrap");
    chk("R12 zero", m_sec[31:0], 32'h0);

    // R3 high word ignores upper bits
    wr(OFF_CNT_HI, 32'hABCD_1234);
    m_sec[47:32] = 16'h1234;
    rd_chk("R3 hi_ignore", OFF_CNT_HI, 32'h0000_1234);

    // R3 write beats a simultaneous wrap
    tick_n(PRE - 1 - m_ph);
    @(negedge clk_i);
    tick_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = OFF_CNT_LO; bus_wdata_i = 32'h0000_0055;
    @(negedge clk_i);
    tick_i = 1'b0; bus_wr_i = 1'b0;
    m_ph = 0; m_sec[31:0] = 32'h55;
    chk_time("R3 wr_wins");

    // R4 frozen pair across a carry
    wr(OFF_CTRL, 32'h0200_0000);
    rd_chk("R4 ctrl", OFF_CTRL, 32'h0200_0000);
    set_time({16'h0005, 32'hFFFF_FFFF});
    tick_n(PRE - 1 - m_ph);
    rd_chk("R4 lo", OFF_CNT_LO, 32'hFFFF_FFFF);
    tick_n(1);
    rd_chk("R4 hi_frozen", OFF_CNT_HI, 32'h0000_0005);
    rd_chk("R4 hi_released", OFF_CNT_HI, 32'h0000_0006);
    rd_chk("R4 lo_after", OFF_CNT_LO, 32'h0);

    // R6 read data holds between reads
    rd(OFF_CNT_HI, v);
    repeat (4) @(negedge clk_i);
    chk("R6 hold", bus_rdata_o, v);

    // R5 no freeze: high read is live
    wr(OFF_CTRL, 32'h0);
    set_time({16'h0009, 32'hFFFF_FFFF});
    tick_n(PRE - 1 - m_ph);
    rd_chk("R5 lo", OFF_CNT_LO, 32'hFFFF_FFFF);
    tick_n(1);
    rd_chk("R5 hi_live", OFF_CNT_HI, 32'h0000_000A);

    // R7 exact alarm match
    set_time(48'h0001_2345_6780);
    wr(OFF_STAT, 32'h3);
    set_alarm(m_sec + 48'd2);
    rd_chk("R7 alm_rb", OFF_ALM_LO, 32'h2345_6782);
    tick_n(PRE - m_ph);
    rd_chk("R7 before", OFF_RAW, 32'h0);
    tick_n(PRE);
    rd_chk("R7 hit", OFF_RAW, 32'h1);
    rd_chk("R7 masked_off", OFF_STAT, 32'h0);
    chk("R11 no_irq_disabled", {31'h0, irq_o}, 32'h0);

    // R7 single-bit near misses
    for (int k = 0; k < 6; k++) begin
      int b;
      case (k) 0: b = 1; 1: b = 13; 2: b = 31; 3: b = 32; 4: b = 39; default: b = 47; endcase
      wr(OFF_STAT, 32'h1);
      set_alarm((m_sec + 48'd1) ^ (48'd1 << b));
      tick_n(PRE - m_ph);
      rd_chk("R7 near_miss", OFF_RAW, 32'h0);
    end
    set_alarm(m_sec + 48'd1);
    tick_n(PRE - m_ph);
    rd_chk("R7 hit2", OFF_RAW, 32'h1);

    // R8 enable set/clear
    wr(OFF_EN_SET, 32'h0);
    rd_chk("R8 set_zero", OFF_EN_SET, 32'h0);
    wr(OFF_EN_SET, 32'h1);
    rd_chk("R8 set", OFF_EN_SET, 32'h1);
    rd_chk("R8 clr_rb", OFF_EN_CLR, 32'h1);
    rd_chk("R8 masked", OFF_STAT, 32'h1);
    chk("R11 irq_on", {31'h0, irq_o}, 32'h1);
    wr(OFF_EN_CLR, 32'h0);
    rd_chk("R8 clr_zero", OFF_EN_SET, 32'h1);
    wr(OFF_EN_CLR, 32'h1);
    rd_chk("R8 clr", OFF_EN_SET, 32'h0);
    chk("R11 irq_off_disabled", {31'h0, irq_o}, 32'h0);
    rd_chk("R8 raw_kept", OFF_RAW, 32'h1);

    // R9 write-one-to-clear
    wr(OFF_STAT, 32'h0);
    rd_chk("R9 zero_write", OFF_RAW, 32'h1);
    wr(OFF_STAT, 32'h1);
    rd_chk("R9 clear", OFF_RAW, 32'h0);

    // R10 external event
    @(negedge clk_i); evt_ext_i = 1'b1;
    @(negedge clk_i); evt_ext_i = 1'b0;
    rd_chk("R10 ext", OFF_RAW, 32'h2);

    // R9 event wins over simultaneous clear
    @(negedge clk_i);
    evt_ext_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = OFF_STAT; bus_wdata_i = 32'h2;
    @(negedge clk_i);
    evt_ext_i = 1'b0; bus_wr_i = 1'b0;
    rd_chk("R9 set_wins", OFF_RAW, 32'h2);

    // R11 level interrupt from bit 1
    wr(OFF_EN_SET, 32'h2);
    chk("R11 irq_bit1", {31'h0, irq_o}, 32'h1);
    repeat (5) @(negedge clk_i);
    chk("R11 irq_level", {31'h0, irq_o}, 32'h1);
    rd_chk("R8 masked_b1", OFF_STAT, 32'h2);
    wr(OFF_STAT, 32'h2);
    chk("R11 irq_cleared", {31'h0, irq_o}, 32'h0);
    rd(OFF_RAW, v2);
    chk("R9 clear_b1", v2, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule